// File: doc/BRIEF.md
# Word-serial Montgomery modular multiplier

This block computes the Montgomery product x·y·R⁻¹ mod m. The operands are m_bits wide, stored as N words of W bits, and R = 2^(W·N). One W-by-W multiplier is shared over time. The block runs an outer loop over the words of x and an inner loop over the words of y and m. Each inner step moves the running accumulator down by one word, so no separate division by the word base is needed. A single conditional subtraction of the modulus finishes the reduction.

Software or a neighbouring controller writes x, y and m one word at a time through a shared write port. It holds the precomputed constant m' = −m⁻¹ mod 2^W on a dedicated input and pulses start. When done pulses, the result can be read one word at a time through a combinational read port. The block does not compute m' or R² mod m, and it does not convert operands into or out of the Montgomery domain.

Top module: `mont_mul`

## Requirements
- R1: After reset, done is low and every result word reads zero.
- R2: For odd m, x < m, y < m and mprime = −m⁻¹ mod 2^W held stable during the operation, the N result words together equal x·y·2^(−W·N) mod m. Word 0 is the least significant word.
- R3: done is high for exactly one cycle. It rises on the clock edge N·(2+2N)+2N+2 counted from the edge that samples start, which is edge 1.
- R4: Each operation uses the word multiplier in exactly N·(2+2N) cycles: two per outer step for the quotient word, and two per inner step.
- R5: A start pulse while an operation is in progress has no effect. The running operation keeps its result and its done timing.
- R6: An operand word is written on a clock edge where op_we is high. op_sel selects the operand: 0 selects x, 1 selects y and 2 selects m. op_addr gives the word index, with word 0 least significant.
- R7: The result is fully reduced (result < m). The modulus is subtracted once if and only if the accumulator is at least m.
- R8: After done, the result stays readable at any res_addr until the next accepted start. Operand writes do not change it.
- R9: R2 and R3 hold for the 32-bit-word configuration (W=32, N=4) and for the 64-bit-word configuration (W=64, N=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| op_we | input | 1 | Operand word write enable |
| op_sel | input | 2 | Operand select: 0 x, 1 y, 2 m |
| op_addr | input | max(1,clog2(N)) | Operand word index |
| op_data | input | W | Operand word data |
| mprime | input | W | −m⁻¹ mod 2^W, held during the operation |
| res_addr | input | max(1,clog2(N)) | Result word index |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | W | Result word at res_addr |

## Verification
The hardest cases to reach from the ports are the two ends of the final reduction. The first is an accumulator that ends with its extra top word set. The second is one that lands between m and R. In both cases the subtraction must be taken, and it must not borrow past the top word. These cases are driven through moduli of every size: full-width all-ones moduli with x = y = m−1, random moduli whose high bits are cleared, and very small moduli such as 3. Every case runs on both word sizes at once, against a bit-serial reference that shares nothing with the word-level datapath. A second start pulse in the middle of each operation checks that it is ignored.

// File: rtl/mm_pkg.sv
// Shared types for the word-serial Montgomery multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package mm_pkg;

    // Operation phases. The multiplier is busy in Q1, Q2, S1 and S2.
    typedef enum logic [3:0] {
        PH_IDLE, // waiting for start
        PH_Q1,   // low word of a_0 + x_i*y_0
        PH_Q2,   // quotient word u_i = low * m'
        PH_S1,   // add x_i*y_j into the carry pair
        PH_S2,   // add u_i*m_j, write word j-1
        PH_FOLD, // merge carry into the top two accumulator words
        PH_SUB,  // word-serial trial subtraction of m
        PH_FIN   // pick the reduced or unreduced result
    } mm_phase_e;

    localparam logic [1:0] SEL_X = 2'd0;
    localparam logic [1:0] SEL_Y = 2'd1;
    localparam logic [1:0] SEL_M = 2'd2;

endpackage

// File: rtl/mm_wordmem.sv
// Operand word store: DEPTH words of W bits, with a combinational read.
// A word is written when we is high and wsel equals this store's ID.
// Assumes: the address is below DEPTH.
module mm_wordmem #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    parameter int ID    = 0,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    wsel,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] words [DEPTH];

    // Clears on reset, then captures the selected word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) words[k] <= '0;
        end else if (we && (wsel == 2'(ID))) begin
            words[waddr] <= wdata;
        end
    end

    // Combinational read port.
    assign rdata = words[raddr];

endmodule

// File: rtl/mm_ctrl.sv
// Sequencer for the Montgomery multiplier: outer index i, inner index j,
// the operation phase, and the one-cycle done pulse.
// Assumes: N >= 2. A start pulse is only honoured in PH_IDLE.
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int N   = 4,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output mm_phase_e     phase,
    output logic          clr,
    output logic [AW-1:0] i_idx,
    output logic [AW-1:0] j_idx,
    output logic          done
);

    localparam logic [AW-1:0] LAST = AW'(N - 1);
    localparam int MULS = N * (2 + 2 * N);
    localparam int MCW  = $clog2(MULS + 1);

    logic [MCW-1:0] mulcnt;

    assign clr = (phase == PH_IDLE) && start;

    // Phase and index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            i_idx <= '0;
            j_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_Q1;
                    i_idx <= '0;
                end
                PH_Q1: phase <= PH_Q2;
                PH_Q2: begin
                    phase <= PH_S1;
                    j_idx <= '0;
                end
                PH_S1: phase <= PH_S2;
                PH_S2: begin
                    if (j_idx == LAST) phase <= PH_FOLD;
                    else begin
                        j_idx <= j_idx + 1'b1;
                        phase <= PH_S1;
                    end
                end
                PH_FOLD: begin
                    if (i_idx == LAST) begin
                        phase <= PH_SUB;
                        j_idx <= '0;
                    end else begin
                        i_idx <= i_idx + 1'b1;
                        phase <= PH_Q1;
                    end
                end
                PH_SUB: begin
                    if (j_idx == LAST) phase <= PH_FIN;
                    else j_idx <= j_idx + 1'b1;
                end
                PH_FIN:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Completion pulse, one cycle after the selection phase.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (phase == PH_FIN);
    end

    // Multiplier-busy cycle counter, kept for the usage check.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) mulcnt <= '0;
        else if (phase == PH_Q1 || phase == PH_Q2 || phase == PH_S1 || phase == PH_S2)
            mulcnt <= mulcnt + 1'b1;
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE));

    p_mul_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIN) |-> (mulcnt == MCW'(MULS)));

    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_S2 && start) |=> (phase == PH_S1 || phase == PH_FOLD));

endmodule

// File: rtl/mm_datapath.sv
// Datapath: a single shared WxW multiplier, the (N+1)-word accumulator,
// the 2W+1-bit carry pair, the quotient word, and the trial-difference store.
// Assumes: m is odd, mprime = -m^-1 mod 2^W, x < m and y < m, and the
// operand inputs are stable while phase is not PH_IDLE.
module mm_datapath
    import mm_pkg::*;
#(
    parameter int W   = 32,
    parameter int N   = 4,
    localparam int AW = $clog2(N),
    localparam int CW = 2 * W + 1,
    localparam int EW = 2 * W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mm_phase_e     phase,
    input  logic          clr,
    input  logic [AW-1:0] j_idx,
    input  logic [W-1:0]  x_word,
    input  logic [W-1:0]  y_word,
    input  logic [W-1:0]  m_word,
    input  logic [W-1:0]  mprime,
    input  logic [AW-1:0] res_addr,
    output logic [W-1:0]  res_data
);

    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic [W-1:0]   acc [N];   // accumulator words 0..N-1
    logic           acc_top;   // accumulator word N (0 or 1)
    logic [W-1:0]   dif [N];   // accumulator minus m
    logic [CW-1:0]  cv;        // carry pair (c, v)
    logic [W-1:0]   u_q;       // quotient word, also low word in Q1
    logic           br;        // subtraction borrow
    logic           use_diff;

    logic [W-1:0]   mul_a, mul_b;
    logic [2*W-1:0] prod;
    logic [W:0]     carry;
    logic [EW-1:0]  s1_ext, s2_ext;
    logic [W+1:0]   fold;
    logic [W:0]     sub_d;
    logic [AW-1:0]  jm1;

    // Operand steering for the shared multiplier.
    always_comb begin
        mul_a = u_q;
        mul_b = m_word;
        case (phase)
            PH_Q1, PH_S1: begin mul_a = x_word; mul_b = y_word; end
            PH_Q2:        begin mul_a = u_q;    mul_b = mprime; end
            default:      begin mul_a = u_q;    mul_b = m_word; end
        endcase
    end

    assign prod = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};

    // Adders: both halves of an inner step, the carry fold, the trial subtract.
    assign carry  = cv[CW-1:W];
    assign s1_ext = EW'(acc[j_idx]) + EW'(prod) + EW'(carry);
    assign s2_ext = EW'(cv) + EW'(prod);
    assign fold   = (W+2)'(acc_top) + (W+2)'(carry);
    assign sub_d  = {1'b0, acc[j_idx]} - {1'b0, m_word} - (W+1)'(br);
    assign jm1    = j_idx - 1'b1;

    // Accumulator, carry pair and quotient updates, by phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                acc[k] <= '0;
                dif[k] <= '0;
            end
            acc_top  <= 1'b0;
            cv       <= '0;
            u_q      <= '0;
            br       <= 1'b0;
            use_diff <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (clr) begin
                    for (int k = 0; k < N; k++) acc[k] <= '0;
                    acc_top  <= 1'b0;
                    use_diff <= 1'b0;
                end
                PH_Q1: u_q <= acc[0] + prod[W-1:0];
                PH_Q2: begin
                    u_q <= prod[W-1:0];
                    cv  <= '0;
                end
                PH_S1: cv <= s1_ext[CW-1:0];
                PH_S2: begin
                    cv <= s2_ext[CW-1:0];
                    if (j_idx != '0) acc[jm1] <= s2_ext[W-1:0];
                end
                PH_FOLD: begin
                    acc[LAST] <= fold[W-1:0];
                    acc_top   <= fold[W];
                    br        <= 1'b0;
                end
                PH_SUB: begin
                    dif[j_idx] <= sub_d[W-1:0];
                    br         <= sub_d[W];
                end
                PH_FIN: use_diff <= acc_top | ~br;
                default: ;
            endcase
        end
    end

    // Result word read.
    assign res_data = use_diff ? dif[res_addr] : acc[res_addr];

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_S1) |-> !s1_ext[EW-1]);

    p_no_overflow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_S2) |-> !s2_ext[EW-1]);

    p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_S2 && j_idx == '0) |-> (s2_ext[W-1:0] == '0));

    p_fold_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FOLD) |-> !fold[W+1]);

    p_below_2m_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIN) |-> !(acc_top && !br));

endmodule

// File: rtl/mont_mul.sv
// Word-serial Montgomery multiplier top: three operand stores, a sequencer
// and the shared-multiplier datapath. Returns x*y*2^(-W*N) mod m.
// Assumes: N >= 2, m odd, x,y < m, mprime = -m^-1 mod 2^W held stable.
module mont_mul
    import mm_pkg::*;
#(
    parameter int W   = 32,
    parameter int N   = 4,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_we,
    input  logic [1:0]    op_sel,
    input  logic [AW-1:0] op_addr,
    input  logic [W-1:0]  op_data,
    input  logic [W-1:0]  mprime,
    input  logic [AW-1:0] res_addr,
    output logic          done,
    output logic [W-1:0]  res_data
);

    mm_phase_e     phase;
    logic          clr;
    logic [AW-1:0] i_idx, j_idx;
    logic [AW-1:0] raddr [3];
    logic [W-1:0]  rdata [3];

    // Read addresses: x follows i; y is word 0 in Q1, else j; m follows j.
    assign raddr[0] = i_idx;
    assign raddr[1] = (phase == PH_Q1) ? '0 : j_idx;
    assign raddr[2] = j_idx;

    for (genvar g = 0; g < 3; g++) begin : g_store
        mm_wordmem #(.W(W), .DEPTH(N), .ID(g)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (op_we),
            .wsel  (op_sel),
            .waddr (op_addr),
            .wdata (op_data),
            .raddr (raddr[g]),
            .rdata (rdata[g])
        );
    end

    mm_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase),
        .clr   (clr),
        .i_idx (i_idx),
        .j_idx (j_idx),
        .done  (done)
    );

    mm_datapath #(.W(W), .N(N)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .clr      (clr),
        .j_idx    (j_idx),
        .x_word   (rdata[0]),
        .y_word   (rdata[1]),
        .m_word   (rdata[2]),
        .mprime   (mprime),
        .res_addr (res_addr),
        .res_data (res_data)
    );

endmodule

// File: tb/tb_mont_mul.sv
`timescale 1ns/1ps
module tb_mont_mul;

    localparam int LAT32 = 4 * (2 + 2 * 4) + 2 * 4 + 2; // 50
    localparam int LAT64 = 2 * (2 + 2 * 2) + 2 * 2 + 2; // 18

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op_we = 1'b0;
    logic [1:0] op_sel = '0;
    logic [1:0] a_addr = '0, a_raddr = '0;
    logic [31:0] a_data = '0, a_mp = '0, a_res;
    logic b_addr = 1'b0, b_raddr = 1'b0;
    logic [63:0] b_data = '0, b_mp = '0, b_res;
    logic a_done, b_done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mont_mul #(.W(32), .N(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_we(op_we), .op_sel(op_sel),
        .op_addr(a_addr), .op_data(a_data), .mprime(a_mp), .res_addr(a_raddr),
        .done(a_done), .res_data(a_res));

    mont_mul #(.W(64), .N(2)) dut_w64 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_we(op_we), .op_sel(op_sel),
        .op_addr(b_addr), .op_data(b_data), .mprime(b_mp), .res_addr(b_raddr),
        .done(b_done), .res_data(b_res));

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit-serial Montgomery reference: halve (t or t+m) 128 times.
    function automatic logic [127:0] mont_ref(input logic [127:0] x, y, m);
        logic [256:0] t;
        t = 257'(x) * 257'(y);
        for (int b = 0; b < 128; b++) begin
            if (t[0]) t = t + 257'(m);
            t = t >> 1;
        end
        if (t >= 257'(m)) t = t - 257'(m);
        return t[127:0];
    endfunction

    function automatic logic [63:0] inv64(input logic [63:0] a);
        logic [63:0] v;
        v = a;
        for (int k = 0; k < 6; k++) v = v * (64'd2 - a * v);
        return v;
    endfunction

    // R6: sel 0 x, 1 y, 2 m; word k holds bits k*W upward.
    task automatic load(input logic [127:0] x, y, m);
        logic [127:0] v;
        logic [63:0] inv;
        inv = inv64(m[63:0]);
        a_mp = -inv[31:0];
        b_mp = -inv;
        for (int s = 0; s < 3; s++) begin
            v = (s == 0) ? x : (s == 1) ? y : m;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                op_we  = 1'b1;
                op_sel = 2'(s);
                a_addr = 2'(k);
                a_data = v[k*32 +: 32];
                b_addr = k[0];
                b_data = v[(k%2)*64 +: 64];
            end
        end
        @(negedge clk);
        op_we = 1'b0;
    endtask

    task automatic read_res(output logic [127:0] ra, output logic [127:0] rb);
        for (int k = 0; k < 4; k++) begin
            a_raddr = 2'(k);
            #0.5;
            ra[k*32 +: 32] = a_res;
        end
        for (int k = 0; k < 2; k++) begin
            b_raddr = k[0];
            #0.5;
            rb[k*64 +: 64] = b_res;
        end
    endtask

    task automatic run(input logic [127:0] x, y, m);
        logic [127:0] exp, ra, rb;
        int cnt, lat_a, lat_b;
        bit pa, pb;
        exp = mont_ref(x, y, m);
        load(x, y, m);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cnt = 1; lat_a = 0; lat_b = 0; pa = 0; pb = 0;
        while (cnt < LAT32 + 4) begin
            @(posedge clk);
            cnt++;
            #1;
            if (cnt == 10) start = 1'b1;     // R5: restart attempt mid-operation
            if (cnt == 11) start = 1'b0;
            if (a_done && lat_a == 0) lat_a = cnt;
            if (b_done && lat_b == 0) lat_b = cnt;
            check(!(a_done && pa), "R3 done pulse W32", 128'(a_done), 128'(0));
            check(!(b_done && pb), "R3 done pulse W64", 128'(b_done), 128'(0));
            pa = a_done; pb = b_done;
        end
        check(lat_a == LAT32, "R3 R4 R5 R9 latency W32", 128'(lat_a), 128'(LAT32));
        check(lat_b == LAT64, "R3 R4 R5 R9 latency W64", 128'(lat_b), 128'(LAT64));
        read_res(ra, rb);
        check(ra == exp, "R2 R6 R9 result W32", ra, exp);
        check(rb == exp, "R2 R6 R9 result W64", rb, exp);
        check(ra < m && rb < m, "R7 reduced", ra, m);
        // R8: overwrite an operand word, then read the result again
        @(negedge clk);
        op_we = 1'b1; op_sel = 2'd0; a_addr = 2'd0; b_addr = 1'b0;
        a_data = ~x[31:0]; b_data = ~x[63:0];
        @(negedge clk);
        op_we = 1'b0;
        read_res(ra, rb);
        check(ra == exp && rb == exp, "R8 result held", ra, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] m, x, y, ra, rb, allf;
        allf = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_res(ra, rb);
        check(a_done == 0 && b_done == 0, "R1 done low", 128'({a_done, b_done}), 128'(0));
        check(ra == 0 && rb == 0, "R1 result zero", ra | rb, 128'(0));

        // Corner cases
        m = allf;
        run(m - 1, m - 1, m);
        run(128'd0, m - 1, m);
        run(m - 1, 128'd1, m);
        m = 128'd3;
        run(128'd2, 128'd2, m);
        run(128'd1, 128'd1, m);
        m = {1'b1, 126'd0, 1'b1};
        run(m - 1, m - 1, m);
        run(128'd1, m - 1, m);

        // Random odd moduli of many sizes
        for (int t = 0; t < 32; t++) begin
            m = {$urandom, $urandom, $urandom, $urandom};
            m = (m >> (t % 8 == 0 ? 0 : $urandom_range(1, 120))) | 128'd1;
            if (m < 128'd3) m = 128'd3;
            x = {$urandom, $urandom, $urandom, $urandom} % m;
            y = {$urandom, $urandom, $urandom, $urandom} % m;
            if (t % 4 == 1) x = 128'd0;
            if (t % 4 == 2) y = 128'd1;
            if (t % 4 == 3) begin x = m - 1; y = m - 1; end
            run(x, y, m);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule